// File: doc/BRIEF.md
# Compare-Capture Timer with Waveform Output

This block is a timer core that runs in a single clock domain. A W-bit up-counter advances on ticks from a power-of-two prescaler. When the count passes its all-ones value, the counter is loaded from a reload register. A control bit decides whether the timer then keeps running or stops after that one wrap. On every counter step, the next value is compared against a match register. A two-flop synchronized input pin stores the live count into a capture register on a selected edge.

The overflow, match and capture events each set a sticky status flag. Software clears a flag by writing 1 to it. The three flags are masked by per-source enables and ORed into one interrupt line. A waveform output pulses for one clock, or toggles, on overflow, on match, or on both. It can serve as a trigger stamp or as a PWM source. A separate general-purpose output follows one control bit.

Software reaches all state through a flat parallel port. A write lands on the clock edge where `wr_en` is high. Reads are combinational from `addr`. The count can be read and rewritten while the timer runs.

Top module: `cc_timer`

## Requirements
- R1: After reset, every readable register reads 0, and `pwm_out`, `irq` and `gpo` are 0.
- R2: When the run bit (CTRL bit 0) is set and the prescaler enable (CTRL bit 2) is clear, the count (address 1) rises by exactly 1 on each clock edge after the one that wrote CTRL.
- R3: When the prescaler enable is set, the count rises once every 2^(S+1) clocks, where S is CTRL bits 5:3. After N edges from the start, the count equals start + floor(N / 2^(S+1)).
- R4: A write to address 1 loads the count on that edge, even while the timer runs, and counting continues from the written value.
- R5: On a tick at the all-ones count, the counter loads the reload value (address 2) and sets status bit 0 (overflow). When auto-reload (CTRL bit 1) is set, the timer keeps running.
- R6: When auto-reload is clear, an overflow also clears the run bit, so the counter stops holding the reload value.
- R7: When a tick makes the count equal the match register (address 3), status bit 1 is set on that same edge. It is not set earlier.
- R8: Status (address 5) is sticky: bit 0 is overflow, bit 1 is match, bit 2 is capture. Writing 1 to a bit clears only that bit.
- R9: `irq` is the OR of the status bits ANDed with the enables at address 6, which use the same bit order.
- R10: CTRL bits 10:9 select the capture edge: 01 is rising, 10 is falling, 11 is both, 00 is none. A selected edge on `cap_in` copies into address 4 the count seen two clocks after the input change, and sets status bit 2. An edge of the other kind is ignored.
- R11: When CTRL bit 6 is 0 (pulse mode), `pwm_out` is high for exactly one clock after each selected event. CTRL bit 7 selects overflow events and bit 8 selects match events.
- R12: When CTRL bit 6 is 1 (toggle mode), `pwm_out` inverts after each selected event and holds between events.
- R13: `gpo` equals CTRL bit 14 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register select |
| wdata | input | W | Write data |
| rdata | output | W | Read data for `addr` |
| cap_in | input | 1 | Capture trigger input, asynchronous |
| pwm_out | output | 1 | Pulse or toggle waveform output |
| gpo | output | 1 | General-purpose output bit |
| irq | output | 1 | Merged interrupt |

## Verification
The assertions assume that software never writes the count in the same cycle in which it expects an overflow reload. They also assume that `addr` is stable whenever `wr_en` is high. The bench drives all writes one full clock wide from falling edges and keeps `addr` steady while writing.

In the random prescaler runs, start values are masked well below the all-ones count. As a result, only the directed corner cases reach overflow. The `cap_in` input changes only at falling edges, so its synchronizer latency is fixed at two clocks.

// File: rtl/cc_timer.sv
module cc_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         cap_in,
  output logic         pwm_out,
  output logic         gpo,
  output logic         irq
);
  localparam logic [2:0] A_CTRL = 3'd0, A_CNT = 3'd1, A_RLD = 3'd2, A_MAT = 3'd3,
                         A_CAP = 3'd4, A_STAT = 3'd5, A_IEN = 3'd6;
  localparam int PSW = 8;

  logic [14:0]    ctrl;
  logic [W-1:0]   cnt, rld, mat, cap;
  logic [2:0]     stat, ien, sync;
  logic [PSW-1:0] pcnt;
  logic           out_q;

  wire run       = ctrl[0];
  wire reload_en = ctrl[1];
  wire ps_en     = ctrl[2];
  wire [2:0] ps_sel  = ctrl[5:3];
  wire tgl       = ctrl[6];
  wire [1:0] out_src = ctrl[8:7];
  wire [1:0] edge_sel = ctrl[10:9];

  wire wr_ctrl = wr_en && addr == A_CTRL;
  wire wr_cnt  = wr_en && addr == A_CNT;
  wire wr_stat = wr_en && addr == A_STAT;

  wire [PSW:0] ps_lim = (9'd2 << ps_sel) - 9'd1;
  wire ps_last = pcnt == ps_lim[PSW-1:0];
  wire tick    = run && (!ps_en || ps_last);

  wire at_max = &cnt;
  wire [W-1:0] cnt_nxt = at_max ? rld : cnt + W'(1);
  wire ovf_ev   = tick && !wr_cnt && at_max;
  wire match_ev = tick && !wr_cnt && cnt_nxt == mat;
  wire cap_ev   = (edge_sel[0] && sync[1] && !sync[2]) ||
                  (edge_sel[1] && !sync[1] && sync[2]);
  wire out_ev   = (out_src[0] && ovf_ev) || (out_src[1] && match_ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      cnt   <= '0;
      rld   <= '0;
      mat   <= '0;
      cap   <= '0;
      stat  <= '0;
      ien   <= '0;
      sync  <= '0;
      pcnt  <= '0;
      out_q <= 1'b0;
    end else begin
      sync <= {sync[1:0], cap_in};

      if (wr_ctrl) ctrl <= wdata[14:0];
      else if (ovf_ev && !reload_en) ctrl[0] <= 1'b0;

      if (wr_en && addr == A_RLD) rld <= wdata;
      if (wr_en && addr == A_MAT) mat <= wdata;
      if (wr_en && addr == A_IEN) ien <= wdata[2:0];

      if (wr_cnt) cnt <= wdata;
      else if (tick) cnt <= cnt_nxt;

      if (!run || !ps_en || wr_cnt || ps_last) pcnt <= '0;
      else pcnt <= pcnt + PSW'(1);

      if (cap_ev) cap <= cnt;

      stat <= (stat & ~(wr_stat ? wdata[2:0] : 3'b000)) | {cap_ev, match_ev, ovf_ev};

      out_q <= tgl ? (out_q ^ out_ev) : out_ev;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = W'(ctrl);
      A_CNT:   rdata = cnt;
      A_RLD:   rdata = rld;
      A_MAT:   rdata = mat;
      A_CAP:   rdata = cap;
      A_STAT:  rdata = W'(stat);
      A_IEN:   rdata = W'(ien);
      default: rdata = '0;
    endcase
  end

  assign pwm_out = out_q;
  assign gpo     = ctrl[14];
  assign irq     = |(stat & ien);
endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [2:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] cnt,
  input logic [W-1:0] rld,
  input logic [14:0]  ctrl,
  input logic [2:0]   stat,
  input logic         ovf_ev
);
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && !ctrl[2] && !(wr_en && addr == 3'd1) && !(&cnt)) |=> cnt == ($past(cnt) + W'(1)));

  assert_live_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1) |=> cnt == $past(wdata));

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> cnt == $past(rld));

  assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ev && !ctrl[1] && !(wr_en && addr == 3'd0)) |=> !ctrl[0]);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 3'd5) |=> ((stat & $past(stat)) == $past(stat)));
endmodule

bind cc_timer cc_timer_chk #(.W(W)) chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .cnt(cnt), .rld(rld), .ctrl(ctrl), .stat(stat), .ovf_ev(ovf_ev)
);

// File: tb/cc_timer_test.sv
module cc_timer_test;
  localparam int W = 32;
  logic clk = 0, rst_n = 0, wr_en = 0, cap_in = 0;
  logic [2:0] addr = 0;
  logic [W-1:0] wdata = 0, rdata;
  logic pwm_out, gpo, irq;
  int tests = 0, fails = 0;
  bit done = 0;

  cc_timer #(.W(W)) uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cap_in(cap_in), .pwm_out(pwm_out), .gpo(gpo), .irq(irq));

  always #2 clk = ~clk;

  function automatic logic [W-1:0] exp_count(logic [W-1:0] start, int n, bit ps, int sel);
    return ps ? start + W'(n / (2 << sel)) : start + W'(n);
  endfunction

  task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [W-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [W-1:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] v, c;
    void'($urandom(32'h5eed_1234));
    step(3); rst_n = 1; step(1);

    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v); chk($sformatf("R1 reg %0d", a), v, 0);
    end
    chk("R1 pwm", W'(pwm_out), 0); chk("R1 irq", W'(irq), 0); chk("R1 gpo", W'(gpo), 0);

    wr(1, 100); wr(0, 1); step(10);
    rd(1, v); chk("R2 plain count", v, 110);

    for (int i = 0; i < 8; i++) begin
      logic [W-1:0] st;
      bit pe;
      int sel, n;
      st = $urandom & 32'h0FFF_FFFF; pe = 1'($urandom); sel = $urandom % 4; n = 20 + $urandom % 200;
      wr(0, 0); wr(1, st); wr(0, 1 | (W'(pe) << 2) | (W'(sel) << 3)); step(n);
      rd(1, v); chk($sformatf("R3 prescale pe=%0d sel=%0d n=%0d", pe, sel, n), v, exp_count(st, n, pe, sel));
    end

    wr(0, 1); step(4); wr(1, 5000); step(3);
    rd(1, v); chk("R4 live write", v, 5003);

    wr(0, 0); wr(1, 32'hFFFF_FFFE); wr(2, 32'h10); wr(3, 32'h5); wr(5, 7); wr(0, 3); step(5);
    rd(1, v); chk("R5 autoreload count", v, 32'h13);
    rd(5, v); chk("R5 overflow flag", v & 1, 1);

    wr(0, 0); wr(1, 40); wr(3, 50); wr(0, 1); step(9);
    rd(5, v); chk("R7 match flag early", (v >> 1) & 1, 0);
    step(1); rd(1, v); chk("R7 count at match", v, 50);
    rd(5, v); chk("R7 match flag", (v >> 1) & 1, 1);

    wr(0, 0); wr(5, 2); rd(5, v); chk("R8 w1c clears only match", v, 1);

    wr(6, 0); chk("R9 irq masked", W'(irq), 0);
    wr(6, 2); chk("R9 irq other source", W'(irq), 0);
    wr(6, 1); chk("R9 irq overflow enabled", W'(irq), 1);
    wr(5, 1); chk("R9 irq after clear", W'(irq), 0);
    wr(6, 0);

    wr(1, 32'hFFFF_FFFE); wr(2, 32'h10); wr(0, 1); step(5);
    rd(1, v); chk("R6 one-shot holds reload", v, 32'h10);
    rd(0, v); chk("R6 run bit cleared", v & 1, 0);

    wr(5, 7); wr(1, 0); wr(0, 1 | (1 << 9)); step(5);
    rd(1, c); cap_in = 1; step(3);
    rd(4, v); chk("R10 rising capture value", v, c + 2);
    rd(5, v); chk("R10 capture flag", (v >> 2) & 1, 1);
    wr(5, 4); cap_in = 0; step(5);
    rd(5, v); chk("R10 falling ignored", (v >> 2) & 1, 0);
    cap_in = 1; wr(0, 1 | (3 << 9)); step(5); wr(5, 4);
    rd(1, c); cap_in = 0; step(3);
    rd(4, v); chk("R10 both-edge falling capture", v, c + 2);
    rd(5, v); chk("R10 both-edge flag", (v >> 2) & 1, 1);

    wr(0, 0); wr(1, 32'hFFFF_FFFD); wr(2, 32'h10); wr(0, 3 | (1 << 7)); step(2);
    chk("R11 pulse before overflow", W'(pwm_out), 0);
    step(1); chk("R11 pulse on overflow", W'(pwm_out), 1);
    step(1); chk("R11 pulse one clock", W'(pwm_out), 0);

    wr(0, 0); wr(1, 32'hFFFF_FFF0); wr(2, 32'hFFFF_FFF0); wr(3, 32'hFFFF_FFF3);
    wr(0, 3 | (1 << 6) | (1 << 8)); step(3);
    chk("R12 toggle on match", W'(pwm_out), 1);
    step(2); chk("R12 toggle holds", W'(pwm_out), 1);
    step(14); chk("R12 toggle on next match", W'(pwm_out), 0);

    wr(0, 1 << 14); chk("R13 gpo high", W'(gpo), 1);
    rd(0, v); chk("R13 ctrl bit", (v >> 14) & 1, 1);
    wr(0, 0); chk("R13 gpo low", W'(gpo), 0);

    finish_run();
  end
endmodule